// File: doc/BRIEF.md
# Strobe-Driven Nine-Bit FIFO with Read Rewind

This block is a first-in/first-out buffer for nine-bit words, so a parity or control bit can travel with each byte. It runs on one system clock. The producer and consumer do not send clocked enables. Each side drives an active-low strobe, and the block acts on the edges of these strobes after passing them through a two-flop synchroniser. Storage is a ring addressed by internal read and write pointers. The depth is a power-of-two parameter, with a default of 256.

The flags are active-low and follow an asynchronous-FIFO convention. A write claims its slot at the falling edge of the write strobe, so Full and Half-Full can assert at that edge. The word itself is committed at the rising edge, and only then does Empty deassert. A read claims its word at the falling edge of the read strobe, so Empty can assert at that edge. The slot is released at the rising edge, and only then do Full and Half-Full deassert. This gives Half-Full hysteresis across a read. Read data is presented with an output-enable that is high only while an accepted read strobe is low.

A low pulse on the rewind input moves the read pointer back to the first location. It leaves the written data and the write pointer untouched, so the same words can be read out a second time. An active-low synchronous clear must be applied before use.

Top module: `strobe_fifo`

## Requirements
- R1: While `clear_n` is low at a clock edge, both pointers and the fill count return to zero, and the block drops any strobe edge. After the clear, `empty_n`=0, `full_n`=1, `half_n`=1 and `dout_oe`=0.
- R2: Words come out in the order they were accepted. The stored word is the value on `din` at the first clock edge after the write strobe rises, not its value at the falling edge.
- R3: Once the FIFO holds DEPTH words, the block ignores a further write strobe: no word is stored and the count never exceeds DEPTH.
- R4: While `empty_n` is low, the block ignores a falling read strobe: `dout_oe` stays 0 and the read pointer does not move.
- R5: After an accepted falling read strobe, `dout_oe` is 1 and `dout` holds the word steadily until the strobe rises. At all other times `dout_oe` is 0.
- R6: `half_n` goes low at the falling edge of the write that takes the count above DEPTH/2. It goes high only at the rising edge of a read that leaves the count at or below DEPTH/2.
- R7: `full_n` goes low at the falling edge of the write that fills the last slot. It goes high at the rising edge of the next read. `full_n` and `empty_n` are never low together.
- R8: `empty_n` goes high at the rising edge of a write into an empty FIFO. It goes low at the falling edge of the read that takes the last word.
- R9: A falling edge on `rewind_n` sets the read pointer to location 0 and keeps the write pointer, provided no strobe is in progress. The flags then follow the new distance, and reads replay from the first word written since the clear. This holds when fewer than DEPTH writes have been made since the clear.
- R10: While `rewind_n` is low, the block drops falling strobe edges. A write pulsed during that time stores nothing.
- R11: Each strobe and `rewind_n` passes through two synchronising flops. The block sees an edge on the third clock edge after the pin changes, and it sees a falling edge only after a settled high level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| clear_n | input | 1 | Synchronous active-low clear |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low read strobe |
| rewind_n | input | 1 | Active-low read rewind |
| din | input | WIDTH | Write data |
| dout | output | WIDTH | Read data, meaningful while dout_oe is 1 |
| dout_oe | output | 1 | Read data enable (high-impedance when 0) |
| empty_n | output | 1 | Active-low empty flag |
| full_n | output | 1 | Active-low full flag |
| half_n | output | 1 | Active-low more-than-half flag |

## Verification
Several cases can only be reached by holding a strobe at one level while checking a flag. These are the split timing of each flag between the two edges of one strobe, and the write pulse dropped during a low rewind. The bench splits every write and read into separate falling-edge and rising-edge steps, so it can sample between them. A write pulse is nested inside the rewind pulse. Replaying the whole history after the rewind then shows that no extra word was stored. The full case is reached with a write ring that has already wrapped. The bench then tries a write beyond full and drains the FIFO, which shows that the extra word never entered.

// File: rtl/strobe_fifo_pkg.sv
package strobe_fifo_pkg;

    // index of each strobe line inside the synchroniser bundle
    localparam int unsigned LINE_WR  = 0;
    localparam int unsigned LINE_RD  = 1;
    localparam int unsigned LINE_RW  = 2;
    localparam int unsigned N_LINES  = 3;

    // per-line event bundle produced by the synchroniser
    typedef struct packed {
        logic fall;     // settled high -> synchronised low
        logic rise;     // settled low  -> synchronised high
        logic settled;  // level seen one cycle earlier
    } strobe_ev_t;

    function automatic int unsigned ptr_bits(input int unsigned depth);
        return (depth < 2) ? 1 : $clog2(depth);
    endfunction

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync
    import strobe_fifo_pkg::*;
#(
    parameter int unsigned LINES = 3,
    parameter int unsigned DW    = 9
) (
    input  logic                    clk,
    input  logic [LINES-1:0]        raw_n,
    input  logic [DW-1:0]           data_raw,
    output strobe_ev_t [LINES-1:0]  ev,
    output logic [DW-1:0]           data_sync
);

    logic [DW-1:0] data_q1, data_q2;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic s1, s2, prev;
        always_ff @(posedge clk) begin
            s1   <= raw_n[g];
            s2   <= s1;
            prev <= s2;
        end
        assign ev[g].fall    = prev & ~s2;
        assign ev[g].rise    = ~prev & s2;
        assign ev[g].settled = prev;
    end

    // data follows the same two-flop path so it lines up with the edges
    always_ff @(posedge clk) begin
        data_q1 <= data_raw;
        data_q2 <= data_q1;
    end
    assign data_sync = data_q2;

endmodule

// File: rtl/fifo_store.sv
module fifo_store #(
    parameter int unsigned DEPTH = 256,
    parameter int unsigned DW    = 9,
    localparam int unsigned AW   = (DEPTH < 2) ? 1 : $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/fifo_flags.sv
module fifo_flags #(
    parameter int unsigned DEPTH = 256,
    localparam int unsigned AW   = (DEPTH < 2) ? 1 : $clog2(DEPTH),
    localparam int unsigned CW   = AW + 1,
    localparam int unsigned HALF = DEPTH / 2
) (
    input  logic [CW-1:0] count,
    input  logic          wr_arm,
    input  logic          rd_arm,
    output logic          empty_n,
    output logic          full_n,
    output logic          half_n
);

    // occupancy as seen by the filling side: a claimed write counts
    logic [CW:0] claimed;
    // occupancy as seen by the draining side: a claimed read is gone
    logic [CW:0] remaining;

    always_comb begin
        claimed   = {1'b0, count} + {{CW{1'b0}}, wr_arm};
        remaining = {1'b0, count} - {{CW{1'b0}}, rd_arm};
        full_n    = !(claimed >= (CW+1)'(DEPTH));
        half_n    = !(claimed >  (CW+1)'(HALF));
        empty_n   = (remaining != '0);
    end

endmodule

// File: rtl/fifo_ctrl.sv
module fifo_ctrl
    import strobe_fifo_pkg::*;
#(
    parameter int unsigned DEPTH = 256,
    parameter int unsigned DW    = 9,
    localparam int unsigned AW   = (DEPTH < 2) ? 1 : $clog2(DEPTH),
    localparam int unsigned CW   = AW + 1
) (
    input  logic          clk,
    input  logic          clear_n,
    input  strobe_ev_t    wr_ev,
    input  strobe_ev_t    rd_ev,
    input  strobe_ev_t    rw_ev,
    input  logic [DW-1:0] din_s,
    input  logic          empty_n,
    input  logic          full_n,
    input  logic [DW-1:0] rdata,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [DW-1:0] wdata,
    output logic [AW-1:0] raddr,
    output logic [CW-1:0] count,
    output logic          wr_arm,
    output logic          rd_arm,
    output logic [DW-1:0] dout,
    output logic          dout_oe
);

    logic [AW-1:0] wptr, rptr;
    logic          blocked;
    logic          wr_go, wr_done, rd_go, rd_done, rw_go;

    always_comb begin
        blocked = !rw_ev.settled || rw_ev.fall;
        wr_go   = wr_ev.fall && full_n  && !blocked && !wr_arm;
        rd_go   = rd_ev.fall && empty_n && !blocked && !rd_arm;
        wr_done = wr_ev.rise && wr_arm;
        rd_done = rd_ev.rise && rd_arm;
        rw_go   = rw_ev.fall && !wr_arm && !rd_arm;
    end

    assign we    = wr_done;
    assign waddr = wptr;
    assign wdata = din_s;
    assign raddr = rptr;

    always_ff @(posedge clk) begin
        if (!clear_n) begin
            wptr    <= '0;
            rptr    <= '0;
            count   <= '0;
            wr_arm  <= 1'b0;
            rd_arm  <= 1'b0;
            dout    <= '0;
            dout_oe <= 1'b0;
        end else begin
            if (wr_go)   wr_arm <= 1'b1;
            if (wr_done) begin
                wr_arm <= 1'b0;
                wptr   <= wptr + 1'b1;
            end
            if (rd_go) begin
                rd_arm  <= 1'b1;
                dout    <= rdata;
                dout_oe <= 1'b1;
            end
            if (rd_done) begin
                rd_arm  <= 1'b0;
                dout_oe <= 1'b0;
                rptr    <= rptr + 1'b1;
            end
            if (rw_go) begin
                rptr  <= '0;
                count <= {1'b0, wptr};
            end else begin
                count <= count + {{AW{1'b0}}, wr_done} - {{AW{1'b0}}, rd_done};
            end
        end
    end

endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo
    import strobe_fifo_pkg::*;
#(
    parameter int unsigned DEPTH = 256,
    parameter int unsigned WIDTH = 9,
    localparam int unsigned AW   = (DEPTH < 2) ? 1 : $clog2(DEPTH),
    localparam int unsigned CW   = AW + 1
) (
    input  logic             clk,
    input  logic             clear_n,
    input  logic             wr_n,
    input  logic             rd_n,
    input  logic             rewind_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic             dout_oe,
    output logic             empty_n,
    output logic             full_n,
    output logic             half_n
);

    strobe_ev_t [N_LINES-1:0] ev;
    logic [N_LINES-1:0] raw_n;
    logic [WIDTH-1:0]   din_s, wdata, rdata;
    logic [AW-1:0]      waddr, raddr;
    logic               we, wr_arm, rd_arm, rd_settled;
    logic [CW-1:0]      count;

    always_comb begin
        raw_n          = '1;
        raw_n[LINE_WR] = wr_n;
        raw_n[LINE_RD] = rd_n;
        raw_n[LINE_RW] = rewind_n;
    end

    strobe_sync #(.LINES(N_LINES), .DW(WIDTH)) u_sync (
        .clk       (clk),
        .raw_n     (raw_n),
        .data_raw  (din),
        .ev        (ev),
        .data_sync (din_s)
    );

    assign rd_settled = ev[LINE_RD].settled;

    fifo_ctrl #(.DEPTH(DEPTH), .DW(WIDTH)) u_ctrl (
        .clk     (clk),
        .clear_n (clear_n),
        .wr_ev   (ev[LINE_WR]),
        .rd_ev   (ev[LINE_RD]),
        .rw_ev   (ev[LINE_RW]),
        .din_s   (din_s),
        .empty_n (empty_n),
        .full_n  (full_n),
        .rdata   (rdata),
        .we      (we),
        .waddr   (waddr),
        .wdata   (wdata),
        .raddr   (raddr),
        .count   (count),
        .wr_arm  (wr_arm),
        .rd_arm  (rd_arm),
        .dout    (dout),
        .dout_oe (dout_oe)
    );

    fifo_store #(.DEPTH(DEPTH), .DW(WIDTH)) u_store (
        .clk   (clk),
        .we    (we),
        .waddr (waddr),
        .wdata (wdata),
        .raddr (raddr),
        .rdata (rdata)
    );

    fifo_flags #(.DEPTH(DEPTH)) u_flags (
        .count   (count),
        .wr_arm  (wr_arm),
        .rd_arm  (rd_arm),
        .empty_n (empty_n),
        .full_n  (full_n),
        .half_n  (half_n)
    );

endmodule

// File: rtl/strobe_fifo_checker.sv
module strobe_fifo_checker #(
    parameter int unsigned DEPTH = 256,
    parameter int unsigned WIDTH = 9,
    localparam int unsigned CW   = ((DEPTH < 2) ? 1 : $clog2(DEPTH)) + 1
) (
    input logic             clk,
    input logic             clear_n,
    input logic             empty_n,
    input logic             full_n,
    input logic             half_n,
    input logic             dout_oe,
    input logic [WIDTH-1:0] dout,
    input logic             rd_settled,
    input logic [CW-1:0]    count
);

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!clear_n)
        count <= CW'(DEPTH));

    assert_full_excludes_empty_R7: assert property (@(posedge clk) disable iff (!clear_n)
        !(!full_n && !empty_n));

    assert_full_implies_half_R6: assert property (@(posedge clk) disable iff (!clear_n)
        !full_n |-> !half_n);

    assert_oe_needs_strobe_low_R5: assert property (@(posedge clk) disable iff (!clear_n)
        dout_oe |-> !rd_settled);

    assert_dout_steady_R5: assert property (@(posedge clk) disable iff (!clear_n)
        (dout_oe && $past(dout_oe)) |-> $stable(dout));

endmodule

bind strobe_fifo strobe_fifo_checker #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .clear_n    (clear_n),
    .empty_n    (empty_n),
    .full_n     (full_n),
    .half_n     (half_n),
    .dout_oe    (dout_oe),
    .dout       (dout),
    .rd_settled (rd_settled),
    .count      (count)
);

// File: tb/strobe_fifo_bench.sv
module strobe_fifo_bench;

    localparam int unsigned DEPTH  = 16;
    localparam int unsigned WIDTH  = 9;
    localparam time         PERIOD = 10ns;

    logic             clk = 1'b0;
    logic             clear_n = 1'b0;
    logic             wr_n = 1'b1, rd_n = 1'b1, rewind_n = 1'b1;
    logic [WIDTH-1:0] din = '0;
    logic [WIDTH-1:0] dout;
    logic             dout_oe, empty_n, full_n, half_n;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [WIDTH-1:0] expq[$];
    logic [WIDTH-1:0] hist[$];

    always #(PERIOD/2) clk = ~clk;

    strobe_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_strobe_fifo (
        .clk(clk), .clear_n(clear_n), .wr_n(wr_n), .rd_n(rd_n),
        .rewind_n(rewind_n), .din(din), .dout(dout), .dout_oe(dout_oe),
        .empty_n(empty_n), .full_n(full_n), .half_n(half_n)
    );

    task automatic check(input string req, input string what,
                         input logic [WIDTH-1:0] got, input logic [WIDTH-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: each new read presentation pops one expected word (R2)
    logic oe_seen = 1'b0;
    always @(negedge clk) begin
        if (dout_oe && !oe_seen) begin
            if (expq.size() == 0) begin
                checks++; errors++;
                $display("FAIL R2 unexpected word: got %0h expected none", dout);
            end else begin
                check("R2", "fifo order", dout, expq.pop_front());
            end
        end
        oe_seen = dout_oe;
    end

    task automatic wr_low(input logic [WIDTH-1:0] w);
        din = ~w;               // wrong value while the strobe falls
        wr_n = 1'b0;
        hold(4);
    endtask

    task automatic wr_high(input logic [WIDTH-1:0] w, input bit accept);
        din = w;
        hold(1);
        wr_n = 1'b1;
        hold(1);
        din = ~w;               // wrong value after the capture edge
        hold(3);
        if (accept) begin
            expq.push_back(w);
            hist.push_back(w);
        end
    endtask

    task automatic write(input logic [WIDTH-1:0] w, input bit accept);
        wr_low(w);
        wr_high(w, accept);
    endtask

    task automatic rd_low();
        rd_n = 1'b0;
        hold(4);
    endtask

    task automatic rd_high();
        rd_n = 1'b1;
        hold(4);
    endtask

    task automatic read();
        rd_low();
        rd_high();
    endtask

    task automatic do_clear();
        clear_n = 1'b0;
        hold(3);
        clear_n = 1'b1;
        hold(1);
        expq.delete();
        hist.delete();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        hold(4);
        do_clear();
        // R1: state after clear
        check("R1", "empty_n after clear", empty_n, 0);
        check("R1", "full_n after clear", full_n, 1);
        check("R1", "half_n after clear", half_n, 1);
        check("R1", "dout_oe after clear", dout_oe, 0);

        // R4: read while empty is ignored
        rd_low();
        check("R4", "oe on empty read", dout_oe, 0);
        rd_high();
        check("R4", "empty_n still low", empty_n, 0);

        // R11: edge takes three clock edges to act
        wr_low(9'h0A5);
        rd_n = 1'b1;
        check("R8", "empty_n low while write strobe low", empty_n, 0);
        din = 9'h0A5;
        hold(1);
        wr_n = 1'b1;
        hold(2);
        check("R11", "empty_n after two edges", empty_n, 0);
        hold(1);
        check("R8", "empty_n high after write rise", empty_n, 1);
        din = 9'h15A;
        hold(2);
        expq.push_back(9'h0A5);
        hist.push_back(9'h0A5);

        // R5/R8: read the only word
        rd_low();
        check("R5", "oe during accepted read", dout_oe, 1);
        check("R8", "empty_n low at read fall of last word", empty_n, 0);
        rd_high();
        check("R5", "oe after read rise", dout_oe, 0);

        // R6: half-full at the fall of the write that exceeds DEPTH/2
        for (int i = 0; i < DEPTH/2; i++) write(WIDTH'(9'h100 + i), 1'b1);
        check("R6", "half_n at exactly half", half_n, 1);
        wr_low(9'h1F0);
        check("R6", "half_n low at write fall", half_n, 0);
        wr_high(9'h1F0, 1'b1);
        rd_low();
        check("R6", "half_n still low during read", half_n, 0);
        rd_high();
        check("R6", "half_n high after read rise", half_n, 1);

        // R9/R10: rewind with a write pulse nested inside
        rewind_n = 1'b0;
        hold(2);
        wr_n = 1'b0;
        hold(4);
        wr_n = 1'b1;
        hold(4);
        rewind_n = 1'b1;
        hold(4);
        expq = hist;
        check("R9", "half_n after rewind distance", half_n, 0);
        check("R9", "empty_n after rewind", empty_n, 1);
        for (int i = 0; i < DEPTH/2 + 2; i++) read();
        check("R10", "empty after replay, no extra word", empty_n, 0);
        check("R9", "replay fully consumed", WIDTH'(expq.size()), 0);

        // R3/R7: fill with a wrapped ring
        for (int i = 0; i < DEPTH - 1; i++) write(WIDTH'(9'h040 + i), 1'b1);
        check("R7", "full_n before last slot", full_n, 1);
        wr_low(9'h0EE);
        check("R7", "full_n low at write fall", full_n, 0);
        check("R6", "half_n low when full", half_n, 0);
        wr_high(9'h0EE, 1'b1);
        write(9'h033, 1'b0);
        check("R3", "full_n after ignored write", full_n, 0);
        rd_low();
        check("R7", "full_n still low during read", full_n, 0);
        rd_high();
        check("R7", "full_n high after read rise", full_n, 1);
        for (int i = 0; i < DEPTH - 1; i++) read();
        check("R3", "empty after draining DEPTH words", empty_n, 0);
        check("R3", "no word left over", WIDTH'(expq.size()), 0);

        // R1: clear with data present
        write(9'h011, 1'b1);
        write(9'h022, 1'b1);
        do_clear();
        check("R1", "empty_n after clear with data", empty_n, 0);
        check("R1", "half_n after clear with data", half_n, 1);
        read();
        check("R1", "no data after clear", dout_oe, 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule